// File: doc/BRIEF.md
# Dual Event-Selectable Performance Counter Pair

This block holds two independent event counters that share one bus of hardware event lines. Each counter has its own 8-bit event code in a single control register. The code picks one source line and also a counting rule. Most codes count one per clock while their line is high. One code counts a buffer-full stall once per unbroken run of asserted cycles. One code adds the number of write-back half-lines (zero to two) reported in the current cycle. Reserved codes never count.

Software reaches the control register and both counters through a small register port. A global enable gates counting. A clear bit zeroes both counters. Each counter wraps to zero and raises a sticky overflow flag, which is also driven on a pin and is cleared by writing one.

Top module: `perf_evt_counter_pair`

## Requirements
- R1: After reset both counters read 0, both overflow flags are 0, the enable bit is 0 and both event codes are 0.
- R2: Address 0 is the control register: bit 0 enable, bit 1 clear-counters (write-only, reads 0), bit 2 overflow of counter A, bit 3 overflow of counter B, bits 15:8 code of counter A, bits 23:16 code of counter B; other bits read 0. Address 1 reads/writes counter A and address 2 counter B, zero-extended to 32 bits. Writes take effect on the next clock edge.
- R3: The following codes add one for each enabled cycle in which their line is high, with these line indices: codes 0x00..0x08 use lines 0..8, 0x0A line 9, 0x0B line 10, 0x0D line 11, 0x10 line 12, 0x11 line 13, 0x12 line 14, 0x14 line 15, 0x15 line 16, 0x16 line 17.
- R4: Code 0x09 watches line 8 and adds one only in the first cycle of each run of consecutive high cycles; the run history is tracked whether or not counting is enabled.
- R5: Code 0x0C adds the 2-bit write-back half-line count input each enabled cycle, so a full-line write-back (value 2) adds two.
- R6: Codes 0x0E, 0x0F, 0x13 and 0x17..0xFF never change the counter.
- R7: With the enable bit at 0, no counter changes except through a register write or a clear.
- R8: Writing the control register with bit 1 set zeroes both counters on that edge, overriding any increment in the same cycle.
- R9: An increment that carries out of the counter width wraps the count and sets that counter's overflow flag. The flag stays set until a control write with its bit at 1 clears it, and a new overflow in the same cycle as the clearing write leaves it set.
- R10: When a control write changes a counter's code, the run history takes the new line's present value, so a line already high at the switch is not counted as a new run by code 0x09.
- R11: A write to a counter's address loads the written value and drops that counter's increment in the same cycle, without touching the overflow flag.
- R12: Both counters observe the same event lines at the same time, each through its own code, without affecting one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_addr_i | input | 2 | Register address for read and write |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from address |
| evt_i | input | 18 | Event condition lines |
| wb_halves_i | input | 2 | Half-lines written back this cycle |
| ovf_o | output | 2 | Sticky overflow flags, bit 0 counter A, bit 1 counter B |

## Verification
The bench builds the block with an 8-bit counter width so that wrap-around and the overflow flag are reached in a few cycles, and so that loading a value near the top is cheap. Every one of the 256 event codes is swept through counter A with the same six-cycle pattern, whose per-cycle, per-run and per-half-line totals are worked out arithmetically. Counter B stays on a fixed code during the sweep, which shows that each counter's selection is separate from the other's. Directed sequences cover enable, clear priority, write priority, overflow set-versus-clear and reselection while a line is high.

// File: rtl/pec_pkg.sv
package pec_pkg;

    localparam int SEL_W     = 8;
    localparam int NUM_LINES = 18;
    localparam int LINE_W    = $clog2(NUM_LINES);

    typedef enum logic [1:0] {
        EK_NONE   = 2'd0,
        EK_LEVEL  = 2'd1,
        EK_RUN    = 2'd2,
        EK_HALVES = 2'd3
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e          kind;
        logic [LINE_W-1:0]  line;
    } evt_map_t;

    function automatic evt_map_t map_code(input logic [SEL_W-1:0] code);
        evt_map_t m;
        m.kind = EK_NONE;
        m.line = '0;
        case (code)
            8'h00, 8'h01, 8'h02, 8'h03, 8'h04,
            8'h05, 8'h06, 8'h07, 8'h08: begin
                m.kind = EK_LEVEL;
                m.line = code[LINE_W-1:0];
            end
            8'h09: begin m.kind = EK_RUN;    m.line = LINE_W'(8);  end
            8'h0A: begin m.kind = EK_LEVEL;  m.line = LINE_W'(9);  end
            8'h0B: begin m.kind = EK_LEVEL;  m.line = LINE_W'(10); end
            8'h0C: begin m.kind = EK_HALVES; m.line = '0;          end
            8'h0D: begin m.kind = EK_LEVEL;  m.line = LINE_W'(11); end
            8'h10: begin m.kind = EK_LEVEL;  m.line = LINE_W'(12); end
            8'h11: begin m.kind = EK_LEVEL;  m.line = LINE_W'(13); end
            8'h12: begin m.kind = EK_LEVEL;  m.line = LINE_W'(14); end
            8'h14: begin m.kind = EK_LEVEL;  m.line = LINE_W'(15); end
            8'h15: begin m.kind = EK_LEVEL;  m.line = LINE_W'(16); end
            8'h16: begin m.kind = EK_LEVEL;  m.line = LINE_W'(17); end
            default: begin m.kind = EK_NONE; m.line = '0; end
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pec_event_decode.sv
module pec_event_decode
    import pec_pkg::*;
(
    input  logic [SEL_W-1:0] code_i,
    output evt_map_t         map_o
);

    always_comb begin
        map_o = map_code(code_i);
    end

endmodule

// File: rtl/pec_counter_lane.sv
module pec_counter_lane
    import pec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 en_i,
    input  logic                 clr_i,
    input  evt_map_t             cur_map_i,
    input  logic                 sel_chg_i,
    input  evt_map_t             nxt_map_i,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic [1:0]           halves_i,
    input  logic                 wr_i,
    input  logic [CNT_W-1:0]     wr_val_i,
    input  logic                 ovf_clr_i,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 ovf_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
        logic             hist;
    } lane_t;

    lane_t lane_d, lane_q;

    logic             cur_lvl;
    logic [1:0]       amt;
    logic [CNT_W:0]   sum;
    logic             ovf_set;
    logic             unused_kind;

    assign unused_kind = ^nxt_map_i.kind;

    always_comb begin
        cur_lvl = evt_i[cur_map_i.line];
        case (cur_map_i.kind)
            EK_LEVEL:  amt = {1'b0, cur_lvl};
            EK_RUN:    amt = {1'b0, cur_lvl & ~lane_q.hist};
            EK_HALVES: amt = halves_i;
            default:   amt = 2'd0;
        endcase
        sum     = {1'b0, lane_q.cnt} + (CNT_W+1)'(amt);
        ovf_set = en_i && !clr_i && !wr_i && sum[CNT_W];

        lane_d      = lane_q;
        lane_d.hist = sel_chg_i ? evt_i[nxt_map_i.line] : cur_lvl;
        if (clr_i) begin
            lane_d.cnt = '0;
        end else if (wr_i) begin
            lane_d.cnt = wr_val_i;
        end else if (en_i) begin
            lane_d.cnt = sum[CNT_W-1:0];
        end
        lane_d.ovf = ovf_set | (lane_q.ovf & ~ovf_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lane_q <= '0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign cnt_o = lane_q.cnt;
    assign ovf_o = lane_q.ovf;

endmodule

// File: rtl/perf_evt_counter_pair.sv
module perf_evt_counter_pair
    import pec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic [1:0]           reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [31:0]          reg_wdata_i,
    output logic [31:0]          reg_rdata_o,
    input  logic [NUM_LINES-1:0] evt_i,
    input  logic [1:0]           wb_halves_i,
    output logic [1:0]           ovf_o
);

    localparam int NUM_CNT = 2;
    localparam int SEL_LSB = 8;

    typedef struct packed {
        logic                          en;
        logic [NUM_CNT-1:0][SEL_W-1:0] sel;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                          ctl_wr;
    logic                          clr_all;
    logic [NUM_CNT-1:0][SEL_W-1:0] sel_new;
    logic [NUM_CNT-1:0]            sel_chg;
    logic [NUM_CNT-1:0]            cnt_wr;
    logic [NUM_CNT-1:0]            ovf_clr;
    logic [CNT_W-1:0]              lane_cnt [NUM_CNT];
    logic [CNT_W-1:0]              wr_val;
    logic                          unused_wdata;

    assign unused_wdata = ^reg_wdata_i;
    assign wr_val       = reg_wdata_i[CNT_W-1:0];

    always_comb begin
        ctl_wr  = reg_wr_i && (reg_addr_i == 2'd0);
        clr_all = ctl_wr && reg_wdata_i[1];
        ctl_d   = ctl_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            sel_new[i] = reg_wdata_i[SEL_LSB + i*SEL_W +: SEL_W];
            sel_chg[i] = ctl_wr && (sel_new[i] != ctl_q.sel[i]);
            cnt_wr[i]  = reg_wr_i && (reg_addr_i == 2'(i + 1));
            ovf_clr[i] = ctl_wr && reg_wdata_i[2 + i];
        end
        if (ctl_wr) begin
            ctl_d.en  = reg_wdata_i[0];
            ctl_d.sel = sel_new;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
        evt_map_t cur_map, nxt_map;

        pec_event_decode u_dec_cur (
            .code_i (ctl_q.sel[g]),
            .map_o  (cur_map)
        );

        pec_event_decode u_dec_nxt (
            .code_i (sel_new[g]),
            .map_o  (nxt_map)
        );

        pec_counter_lane #(.CNT_W(CNT_W)) u_lane (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (ctl_q.en),
            .clr_i     (clr_all),
            .cur_map_i (cur_map),
            .sel_chg_i (sel_chg[g]),
            .nxt_map_i (nxt_map),
            .evt_i     (evt_i),
            .halves_i  (wb_halves_i),
            .wr_i      (cnt_wr[g]),
            .wr_val_i  (wr_val),
            .ovf_clr_i (ovf_clr[g]),
            .cnt_o     (lane_cnt[g]),
            .ovf_o     (ovf_o[g])
        );
    end

    always_comb begin
        case (reg_addr_i)
            2'd0:    reg_rdata_o = {8'h00, ctl_q.sel[1], ctl_q.sel[0],
                                    4'h0, ovf_o[1], ovf_o[0], 1'b0, ctl_q.en};
            2'd1:    reg_rdata_o = 32'(lane_cnt[0]);
            2'd2:    reg_rdata_o = 32'(lane_cnt[1]);
            default: reg_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [1:0]       addr,
    input logic             wr,
    input logic [31:0]      wdata,
    input logic             en_q,
    input logic [7:0]       sel_a,
    input logic [CNT_W-1:0] cnt_a,
    input logic [CNT_W-1:0] cnt_b,
    input logic [1:0]       ovf
);

    logic rsv_a;
    logic unused_w;

    assign unused_w = ^wdata;
    assign rsv_a = (sel_a > 8'h16) || (sel_a == 8'h13) ||
                   (sel_a == 8'h0E) || (sel_a == 8'h0F);

    assert_hold_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_q && !wr) |=> ($stable(cnt_a) && $stable(cnt_b)));

    assert_clear_both_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && addr == 2'd0 && wdata[1]) |=> (cnt_a == '0 && cnt_b == '0));

    assert_write_wins_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr && addr == 2'd1) |=> (cnt_a == $past(wdata[CNT_W-1:0])));

    assert_ovf_a_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ovf[0]) |-> $past(wr && addr == 2'd0 && wdata[2]));

    assert_ovf_b_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(ovf[1]) |-> $past(wr && addr == 2'd0 && wdata[3]));

    assert_ovf_wraps_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf[0]) |-> (cnt_a < $past(cnt_a)));

    assert_reserved_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsv_a && !wr) |=> $stable(cnt_a));

    assert_step_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wr) |=> ((cnt_a - $past(cnt_a)) <= CNT_W'(2)));

endmodule

bind perf_evt_counter_pair pec_checker #(.CNT_W(CNT_W)) u_pec_checker (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr   (reg_addr_i),
    .wr     (reg_wr_i),
    .wdata  (reg_wdata_i),
    .en_q   (ctl_q.en),
    .sel_a  (ctl_q.sel[0]),
    .cnt_a  (lane_cnt[0]),
    .cnt_b  (lane_cnt[1]),
    .ovf    (ovf_o)
);

// File: tb/tb_perf_evt_counter_pair.sv
module tb_perf_evt_counter_pair;

    localparam int CW = 8;
    localparam int NL = 18;

    logic          clk = 1'b0;
    logic          rst_ni = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] evt = '0;
    logic [1:0]    wb = '0;
    logic [1:0]    ovf;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    perf_evt_counter_pair #(.CNT_W(CW)) dut (
        .clk_i       (clk),
        .rst_ni      (rst_ni),
        .reg_addr_i  (reg_addr),
        .reg_wr_i    (reg_wr),
        .reg_wdata_i (reg_wdata),
        .reg_rdata_o (reg_rdata),
        .evt_i       (evt),
        .wb_halves_i (wb),
        .ovf_o       (ovf)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // entered just after a falling edge; returns at the next falling edge
    task automatic wreg(input logic [1:0] a, input logic [31:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rreg(input logic [1:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    function automatic logic [31:0] ctl(input logic [7:0] sa, input logic [7:0] sb,
                                        input logic en, input logic clr, input logic [1:0] oc);
        return {8'h00, sb, sa, 4'h0, oc, clr, en};
    endfunction

    function automatic bit is_rsv(input int c);
        return (c > 'h16) || (c == 'h13) || (c == 'h0E) || (c == 'h0F);
    endfunction

    function automatic int line_of(input int c);
        if (c <= 8)   return c;
        if (c == 9)   return 8;
        if (c == 'hA) return 9;
        if (c == 'hB) return 10;
        if (c == 'hD) return 11;
        if (c <= 'h12) return c - 'h10 + 12;
        return c - 'h14 + 15;
    endfunction

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [5:0]  pat;
        pat = 6'b011011;

        repeat (3) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);

        // R1 reset state
        rreg(2'd0, v); check("R1 control", v, 32'h0);
        rreg(2'd1, v); check("R1 counter A", v, 32'h0);
        rreg(2'd2, v); check("R1 counter B", v, 32'h0);
        check("R1 overflow pins", {30'h0, ovf}, 32'h0);
        rreg(2'd3, v); check("R2 unused address", v, 32'h0);

        // R3 R4 R5 R6 R12: sweep every code through counter A, counter B on code 7
        for (int c = 0; c < 256; c++) begin
            int exp_a, exp_b;
            evt = '0; wb = '0;
            wreg(2'd0, ctl(8'(c), 8'h07, 1'b1, 1'b1, 2'b00));
            for (int k = 0; k < 6; k++) begin
                evt = '0; wb = '0;
                if (pat[k]) begin
                    if (is_rsv(c))     evt = '1;
                    else if (c == 'hC) wb  = 2'd2;
                    else               evt[line_of(c)] = 1'b1;
                end
                @(negedge clk);
            end
            evt = '0; wb = '0;
            if (is_rsv(c))     exp_a = 0;
            else if (c == 9)   exp_a = 2;
            else if (c == 'hC) exp_a = 8;
            else               exp_a = 4;
            exp_b = (is_rsv(c) || c == 7) ? 4 : 0;
            rreg(2'd1, v);
            if (is_rsv(c))      check("R6 reserved code", v, 32'(exp_a));
            else if (c == 9)    check("R4 per-run code", v, 32'(exp_a));
            else if (c == 'hC)  check("R5 half-line code", v, 32'(exp_a));
            else                check("R3 per-cycle code", v, 32'(exp_a));
            rreg(2'd2, v);
            check("R12 counter B independent", v, 32'(exp_b));
            rreg(2'd0, v);
            check("R2 control readback", v, ctl(8'(c), 8'h07, 1'b1, 1'b0, 2'b00));
        end

        // R7 disabled
        wreg(2'd0, ctl(8'h07, 8'h07, 1'b0, 1'b1, 2'b00));
        evt[7] = 1'b1;
        repeat (5) @(negedge clk);
        evt = '0;
        rreg(2'd1, v); check("R7 disabled A", v, 32'h0);
        rreg(2'd2, v); check("R7 disabled B", v, 32'h0);

        // R8 clear beats increment
        wreg(2'd0, ctl(8'h07, 8'h07, 1'b1, 1'b0, 2'b00));
        evt[7] = 1'b1;
        repeat (3) @(negedge clk);
        rreg(2'd1, v); check("R3 counting before clear", v, 32'd3);
        wreg(2'd0, ctl(8'h07, 8'h07, 1'b1, 1'b1, 2'b00));
        evt = '0;
        rreg(2'd1, v); check("R8 clear A", v, 32'h0);
        rreg(2'd2, v); check("R8 clear B", v, 32'h0);

        // R9 wrap and sticky overflow
        wreg(2'd0, ctl(8'h07, 8'h13, 1'b1, 1'b1, 2'b00));
        wreg(2'd1, 32'd254);
        evt[7] = 1'b1;
        repeat (3) @(negedge clk);
        evt = '0;
        rreg(2'd1, v); check("R9 wrapped count", v, 32'd1);
        check("R9 overflow pin A", {30'h0, ovf}, 32'h1);
        repeat (3) @(negedge clk);
        rreg(2'd0, v); check("R9 sticky flag", v, ctl(8'h07, 8'h13, 1'b1, 1'b0, 2'b01));
        wreg(2'd0, ctl(8'h07, 8'h13, 1'b1, 1'b0, 2'b01));
        check("R9 write-one clears", {30'h0, ovf}, 32'h0);
        wreg(2'd1, 32'd255);
        evt[7] = 1'b1;
        wreg(2'd0, ctl(8'h07, 8'h13, 1'b1, 1'b0, 2'b01));
        evt = '0;
        rreg(2'd1, v); check("R9 wrap during clear", v, 32'h0);
        check("R9 set beats clear", {30'h0, ovf}, 32'h1);
        wreg(2'd0, ctl(8'h07, 8'h13, 1'b1, 1'b0, 2'b01));

        // R11 write beats increment
        evt[7] = 1'b1;
        wreg(2'd1, 32'd10);
        evt = '0;
        rreg(2'd1, v); check("R11 write wins", v, 32'd10);
        check("R11 no overflow side effect", {30'h0, ovf}, 32'h0);

        // R10 reselection with line already high
        wreg(2'd0, ctl(8'h07, 8'h13, 1'b1, 1'b1, 2'b00));
        evt[8] = 1'b1;
        wreg(2'd0, ctl(8'h09, 8'h13, 1'b1, 1'b0, 2'b00));
        repeat (3) @(negedge clk);
        rreg(2'd1, v); check("R10 ongoing run not counted", v, 32'h0);
        evt[8] = 1'b0; @(negedge clk);
        evt[8] = 1'b1; @(negedge clk);
        evt[8] = 1'b0;
        rreg(2'd1, v); check("R4 new run counted", v, 32'd1);

        done = 1'b1;
        finish_run();
    end

endmodule